// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This block sits beside a NAND flash data path and watches the bytes of one 512-byte sector as they go by. Each byte is complemented, widened to a 10-bit symbol and pushed through a Reed-Solomon remainder generator over GF(2^10). The generator produces six 10-bit check symbols. The host reads these symbols back as eight bytes and keeps them in the spare area of the page. Because the data is complemented before coding, an erased sector produces parity that reads back as all 0xFF.

On a page read, the host streams the 512 data bytes and then the 8 stored check bytes. The engine recomputes the parity and compares it with the stored copy. It raises a single error bit when the two differ, so the host can skip syndrome work when a sector is clean. After such a check, the plain code bank holds the difference between the computed and stored parity, ready for host-side decoding. Locating and correcting errors is left to the host.

A small register port gives access to a control register, a check register and two eight-byte views of the code. One view is plain with each byte bit-reversed. The other view is complemented.

Top module: `rs_ecc_engine`

## Requirements
- R1: The parity symbols p5..p0 equal the remainder of x^6·m(x) divided by g(x) = (x+1)(x+α)(x+α^2)(x+α^3)(x+α^4)(x+α^5) over GF(2^10), where α is a root of x^10+x^3+1. m(x) takes its symbols from the bitwise complement of each data byte, zero-extended to 10 bits, with the first byte as the highest-degree coefficient.
- R2: After a write pass over an all-0xFF sector, all eight complemented-bank bytes read 0xFF.
- R3: The 64-bit packed code holds symbol pj in bits [10·(5−j)+9 : 10·(5−j)], so p5 sits in the low bits of byte 0. Byte k is bits [8k+7:8k], and bits [63:60] are 0. In the complemented bank these pad bits therefore read as 1.
- R4: Register 16+k returns the complement of packed byte k. Register 8+k returns packed byte k with its bit order reversed (bit 0 swapped with bit 7, and so on).
- R5: Register map: address 0 is control, reading back {0, generate, feed, 00000}. Address 1 is check, with the error flag in bit 7. Addresses 8–15 are the plain bank and 16–23 the complemented bank. Every other address reads 0.
- R6: Writing control with bit 7 set zeroes the parity, the byte count and the error flag. Bit 6 selects generate (write) mode and bit 5 enables the byte feed. While bit 5 is 0, stream bytes change nothing.
- R7: Only the first 512 accepted bytes after a clear enter the parity. In generate mode, further bytes are ignored.
- R8: In check mode (bit 6 clear), accepted bytes 512..519 are taken as the stored code, in complemented-bank form. The check bit becomes 1 one clock after byte 519 if the stored code differs from the computed code in bits [59:0], and 0 otherwise. It then holds until the next clear.
- R9: After a check, the plain bank presents the packed XOR of the computed and stored parity. This is zero for a clean sector. Flipping bit 0 of stored byte k yields 0x80 in plain byte k.
- R10: After reset, control and check read 0, the plain bank reads 0 and the complemented bank reads all 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address for reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational register read data |
| streamValid | input | 1 | A sector or code byte is present this cycle |
| streamByte | input | 8 | Sector or code byte being observed |

## Verification
Parity is tried on an erased sector, an all-zero sector, a ramp, two pseudo-random fills and a sector that is erased except for one byte. Erased versus all-zero tells apart whether the complement is applied before coding. The ramp and random fills separate correct generator coefficients and symbol order from near misses. The single non-blank byte isolates the contribution of one position. Each pattern is then read back clean and with one flipped byte, placed in the data or in the stored code, to show that the flag separates valid from damaged codewords. Where the flip lands in the stored code, the remainder pattern it leaves is also checked.

// File: rtl/rsecc_pkg.sv
package rsecc_pkg;
  parameter int SYM_W        = 10;
  parameter int NPAR         = 6;
  parameter int SECTOR_BYTES = 512;
  parameter int FIELD_POLY   = 'h409;
  parameter int BYTE_W       = 8;
  parameter int ADDR_W       = 5;

  localparam int CODE_BITS = SYM_W * NPAR;
  localparam int ECC_BYTES = (CODE_BITS + BYTE_W - 1) / BYTE_W;
  localparam int PACK_W    = ECC_BYTES * BYTE_W;
  localparam int PAD_W     = PACK_W - CODE_BITS;
  localparam int TOTAL     = SECTOR_BYTES + ECC_BYTES;
  localparam int CNT_W     = $clog2(TOTAL + 1);
  localparam int IDX_W     = $clog2(ECC_BYTES);

  localparam int CTRL_CLR_BIT  = 7;
  localparam int CTRL_GEN_BIT  = 6;
  localparam int CTRL_FEED_BIT = 5;
  localparam int CHECK_ERR_BIT = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CHECK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PLAIN = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_INV   = ADDR_W'(16);

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NPAR-1:0][SYM_W-1:0] parVec_t;

  typedef struct packed {
    logic clr;
    logic shift;
    logic capture;
    logic compare;
  } strobe_t;

  function automatic sym_t gfMul(sym_t a, sym_t b);
    sym_t acc = '0;
    sym_t sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[SYM_W-1]) sh = (sh << 1) ^ sym_t'(FIELD_POLY);
      else             sh = sh << 1;
    end
    return acc;
  endfunction

  // low coefficients of the monic generator with roots alpha^0 .. alpha^(NPAR-1)
  function automatic parVec_t gfGenPoly();
    logic [NPAR:0][SYM_W-1:0] g;
    sym_t root;
    g    = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int r = 0; r < NPAR; r++) begin
      for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gfMul(g[j], root);
      g[0] = gfMul(g[0], root);
      root = gfMul(root, sym_t'(2));
    end
    return g[NPAR-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] revByte(logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/rs_ecc_ctrl.sv
module rs_ecc_ctrl
  import rsecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              streamValid,
  output strobe_t           strb,
  output logic              genMode,
  output logic              feedEn
);
  localparam logic [CNT_W-1:0] CNT_SECTOR = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] CNT_TOTAL  = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] byteCnt;
  logic ctrlHit;
  logic accept;

  assign ctrlHit = regWrEn && (regAddr == A_CTRL);
  assign accept  = streamValid && feedEn;

  always_comb begin
    strb.clr     = ctrlHit && regWrData[CTRL_CLR_BIT];
    strb.shift   = accept && (byteCnt < CNT_SECTOR);
    strb.capture = accept && !genMode && (byteCnt >= CNT_SECTOR) && (byteCnt < CNT_TOTAL);
    strb.compare = strb.capture && (byteCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genMode <= 1'b0;
      feedEn  <= 1'b0;
      byteCnt <= '0;
    end else begin
      if (ctrlHit) begin
        genMode <= regWrData[CTRL_GEN_BIT];
        feedEn  <= regWrData[CTRL_FEED_BIT];
      end
      if (strb.clr)
        byteCnt <= '0;
      else if (accept && (byteCnt < CNT_TOTAL))
        byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  // R7: the byte position never runs past sector plus code
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_TOTAL);

  // R7: a parity step leaves the position inside the sector
  a_r7_shift_window: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (byteCnt <= CNT_SECTOR));

  // R6: with the feed off, stream bytes do not move the position
  a_r6_freeze_count: assert property (@(posedge clk) disable iff (!rstN)
    (!feedEn && !strb.clr) |=> $stable(byteCnt));
endmodule

// File: rtl/rs_ecc_datapath.sv
module rs_ecc_datapath
  import rsecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              genMode,
  input  logic              feedEn,
  input  logic [BYTE_W-1:0] streamByte,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regRdData
);
  localparam parVec_t GEN = gfGenPoly();

  parVec_t           parReg;
  parVec_t           parNext;
  sym_t              inSym;
  sym_t              feedback;
  logic [PACK_W-1:0] packedPar;
  logic [PACK_W-1:0] storedVec;
  logic [PACK_W-1:0] fullStored;
  logic [CODE_BITS-1:0] diffBits;
  logic [CODE_BITS-1:0] remReg;
  logic              checked;
  logic              errFlag;
  logic [PACK_W-1:0] viewVec;

  // remainder generator, one symbol per accepted sector byte
  assign inSym    = {{(SYM_W-BYTE_W){1'b0}}, ~streamByte};
  assign feedback = inSym ^ parReg[NPAR-1];
  assign parNext[0] = gfMul(feedback, GEN[0]);

  for (genvar j = 1; j < NPAR; j++) begin : g_stage
    assign parNext[j] = parReg[j-1] ^ gfMul(feedback, GEN[j]);
  end

  // highest-index symbol in the lowest packed bits
  for (genvar j = 0; j < NPAR; j++) begin : g_pack
    assign packedPar[SYM_W*(NPAR-1-j) +: SYM_W] = parReg[j];
  end
  if (PAD_W > 0) begin : g_pad
    assign packedPar[PACK_W-1:CODE_BITS] = '0;
  end

  assign fullStored = {streamByte, storedVec[PACK_W-1:BYTE_W]};
  assign diffBits   = packedPar[CODE_BITS-1:0] ^ ~fullStored[CODE_BITS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parReg    <= '0;
      storedVec <= '0;
      remReg    <= '0;
      checked   <= 1'b0;
      errFlag   <= 1'b0;
    end else if (strb.clr) begin
      parReg    <= '0;
      storedVec <= '0;
      remReg    <= '0;
      checked   <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (strb.shift)   parReg    <= parNext;
      if (strb.capture) storedVec <= fullStored;
      if (strb.compare) begin
        remReg  <= diffBits;
        checked <= 1'b1;
        errFlag <= |diffBits;
      end
    end
  end

  if (PAD_W > 0) begin : g_view_pad
    assign viewVec = checked ? {{PAD_W{1'b0}}, remReg} : packedPar;
  end else begin : g_view_nopad
    assign viewVec = checked ? remReg : packedPar;
  end

  // register read mux
  logic [ADDR_W-1:0] plainOff;
  logic [ADDR_W-1:0] invOff;
  logic [IDX_W-1:0]  plainSel;
  logic [IDX_W-1:0]  invSel;
  assign plainOff = regAddr - A_PLAIN;
  assign invOff   = regAddr - A_INV;
  assign plainSel = plainOff[IDX_W-1:0];
  assign invSel   = invOff[IDX_W-1:0];

  always_comb begin
    regRdData = '0;
    if (regAddr == A_CTRL) begin
      regRdData[CTRL_GEN_BIT]  = genMode;
      regRdData[CTRL_FEED_BIT] = feedEn;
    end else if (regAddr == A_CHECK) begin
      regRdData[CHECK_ERR_BIT] = errFlag;
    end else if (regAddr >= A_PLAIN && plainOff < ADDR_W'(ECC_BYTES)) begin
      regRdData = revByte(viewVec[BYTE_W*plainSel +: BYTE_W]);
    end else if (regAddr >= A_INV && invOff < ADDR_W'(ECC_BYTES)) begin
      regRdData = ~viewVec[BYTE_W*invSel +: BYTE_W];
    end
  end

  // R6: parity moves only on a feed step or a clear
  a_r6_parity_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shift && !strb.clr) |=> $stable(parReg));

  // R6: a clear leaves parity zero and the flag low
  a_r6_clear_state: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (parReg == '0 && !errFlag && !checked));

  // R8: once checked, the flag holds until the next clear
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (checked && !strb.clr && !strb.compare) |=> $stable(errFlag));

  // R8: the flag can only rise on the cycle after a compare
  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(strb.compare));

  // R7: parity does not change while stored code bytes arrive
  a_r7_code_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.clr) |=> $stable(parReg));
endmodule

// File: rtl/rs_ecc_engine.sv
module rs_ecc_engine
  import rsecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              streamValid,
  input  logic [BYTE_W-1:0] streamByte
);
  strobe_t strb;
  logic    genMode;
  logic    feedEn;

  rs_ecc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .streamValid (streamValid),
    .strb        (strb),
    .genMode     (genMode),
    .feedEn      (feedEn)
  );

  rs_ecc_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .genMode    (genMode),
    .feedEn     (feedEn),
    .streamByte (streamByte),
    .regAddr    (regAddr),
    .regRdData  (regRdData)
  );
endmodule

// File: tb/test_rs_ecc_engine.sv
`timescale 1ns/1ps
module test_rs_ecc_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       streamValid = 1'b0;
  logic [7:0] streamByte = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rs_ecc_engine i_rs_ecc_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .streamValid(streamValid), .streamByte(streamByte)
  );

  // {kind[3:0], seed[7:0], flipIndex[11:0]}
  localparam logic [23:0] VEC [6] = '{
    {4'd0, 8'd0,   12'd100},
    {4'd1, 8'd0,   12'd0},
    {4'd2, 8'd0,   12'd511},
    {4'd3, 8'd37,  12'd515},
    {4'd3, 8'd201, 12'd256},
    {4'd4, 8'd77,  12'd519}
  };

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] bMul(logic [9:0] a, logic [9:0] b);
    logic [18:0] p = '0;
    for (int i = 0; i < 10; i++) if (b[i]) p = p ^ (19'(a) << i);
    for (int k = 18; k >= 10; k--) if (p[k]) p = p ^ (19'(11'h409) << (k - 10));
    return p[9:0];
  endfunction

  function automatic logic [7:0] patByte(int kind, int seed, int i);
    case (kind)
      0: return 8'hFF;
      1: return 8'h00;
      2: return i[7:0];
      3: return 8'((i * seed) ^ (i >> 3) ^ (seed << 1));
      default: return (i == seed) ? 8'h5A : 8'hFF;
    endcase
  endfunction

  // long division of x^6*m(x) by the generator, returns the packed code
  function automatic logic [63:0] model(int kind, int seed, int nBytes);
    logic [9:0] g [7];
    logic [9:0] arr [518];
    logic [9:0] root;
    logic [9:0] c;
    logic [63:0] pk;
    for (int j = 0; j < 7; j++) g[j] = '0;
    g[0] = 10'd1;
    root = 10'd1;
    for (int r = 0; r < 6; r++) begin
      for (int j = 6; j > 0; j--) g[j] = g[j-1] ^ bMul(g[j], root);
      g[0] = bMul(g[0], root);
      root = bMul(root, 10'd2);
    end
    for (int i = 0; i < 518; i++) arr[i] = '0;
    for (int i = 0; i < 512; i++) arr[i] = {2'b00, ~patByte(kind, seed, i)};
    for (int i = 0; i < 512; i++) begin
      c = arr[i];
      if (c != 0) for (int k = 0; k <= 6; k++) arr[i+k] = arr[i+k] ^ bMul(c, g[6-k]);
    end
    pk = '0;
    for (int t = 0; t < 6; t++) pk[10*t +: 10] = arr[512+t];
    if (nBytes < 0) pk = '0;
    return pk;
  endfunction

  function automatic logic [63:0] revBytes(logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) for (int b = 0; b < 8; b++) r[8*k+b] = v[8*k+7-b];
    return r;
  endfunction

  task automatic wrReg(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic rdBank(logic [4:0] base, output logic [63:0] v);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      rdReg(base + 5'(k), d);
      v[8*k +: 8] = d;
    end
  endtask

  // streams bytes first..last-1 of the sector plus stored code
  task automatic sendRange(int kind, int seed, logic [63:0] pk, int flip, int first, int last);
    logic [7:0] b;
    for (int i = first; i < last; i++) begin
      if (i < 512) b = patByte(kind, seed, i);
      else if (i < 520) b = ~pk[8*(i-512) +: 8];
      else b = 8'(i * 7);
      if (i == flip) b = b ^ 8'h01;
      @(negedge clk);
      streamValid = 1'b1; streamByte = b;
    end
    @(negedge clk);
    streamValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [63:0] v;
    logic [63:0] pk;
    int kind, seed, flip;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state, R5 map
    rdReg(5'd0, d);  chk("R10", "ctrl after reset", 64'(d), 64'h0);
    rdReg(5'd1, d);  chk("R10", "check after reset", 64'(d), 64'h0);
    rdBank(5'd8, v); chk("R10", "plain bank after reset", v, 64'h0);
    rdBank(5'd16, v); chk("R10", "inverted bank after reset", v, {64{1'b1}});
    rdReg(5'd30, d); chk("R5", "unmapped address", 64'(d), 64'h0);

    // vector table: write pass, clean check, damaged check
    for (int n = 0; n < 6; n++) begin
      kind = int'(VEC[n][23:20]);
      seed = int'(VEC[n][19:12]);
      flip = int'(VEC[n][11:0]);
      pk = model(kind, seed, 512);

      wrReg(5'd0, 8'hE0);
      rdReg(5'd0, d); chk("R5", "ctrl readback gen+feed", 64'(d), 64'h60);
      sendRange(kind, seed, pk, -1, 0, 512);
      wrReg(5'd0, 8'h00);
      rdBank(5'd16, v);
      chk(kind == 0 ? "R2" : "R1", "inverted bank code", v, ~pk);
      rdBank(5'd8, v);
      chk("R4", "plain bank bit-reversed code", v, revBytes(pk));
      chk("R3", "pad bits of plain byte 7", 64'(v[59:56]), 64'h0);

      wrReg(5'd0, 8'hA0);
      sendRange(kind, seed, pk, -1, 0, 520);
      rdReg(5'd1, d); chk("R8", "clean sector flag", 64'(d), 64'h0);
      rdBank(5'd8, v); chk("R9", "clean remainder", v, 64'h0);

      wrReg(5'd0, 8'hA0);
      sendRange(kind, seed, pk, flip, 0, 520);
      rdReg(5'd1, d); chk("R8", "damaged sector flag", 64'(d), 64'h80);
      if (flip >= 512) begin
        rdBank(5'd8, v);
        chk("R9", "remainder of stored-byte flip", v, 64'h80 << (8 * (flip - 512)));
      end
    end

    // R6: frozen engine ignores stream bytes
    pk = model(2, 0, 512);
    wrReg(5'd0, 8'hE0);
    sendRange(2, 0, pk, -1, 0, 512);
    wrReg(5'd0, 8'h00);
    sendRange(3, 9, pk, -1, 0, 40);
    rdBank(5'd16, v); chk("R6", "code unchanged while frozen", v, ~pk);

    // R7: bytes past the sector do not enter the parity in generate mode
    pk = model(3, 99, 512);
    wrReg(5'd0, 8'hE0);
    sendRange(3, 99, pk, -1, 0, 512);
    sendRange(3, 99, pk, -1, 520, 540);
    wrReg(5'd0, 8'h00);
    rdBank(5'd16, v); chk("R7", "extra bytes ignored", v, ~pk);

    // R8: flag timing and hold, R6 clear
    pk = model(4, 3, 512);
    wrReg(5'd0, 8'hA0);
    sendRange(4, 3, pk, 5, 0, 519);
    rdReg(5'd1, d); chk("R8", "flag low before last code byte", 64'(d), 64'h0);
    @(negedge clk);
    streamValid = 1'b1; streamByte = ~pk[63:56];
    @(negedge clk);
    streamValid = 1'b0;
    #1 chk("R8", "flag one clock after last byte", 64'(i_rs_ecc_engine.regRdData), 64'h80);
    sendRange(0, 0, pk, -1, 0, 30);
    rdReg(5'd1, d); chk("R8", "flag holds after more bytes", 64'(d), 64'h80);
    wrReg(5'd0, 8'h80);
    rdReg(5'd1, d); chk("R6", "clear drops flag", 64'(d), 64'h0);
    rdReg(5'd0, d); chk("R6", "clear-only leaves feed off", 64'(d), 64'h0);
    rdBank(5'd16, v); chk("R6", "clear zeroes parity", v, {64{1'b1}});

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule